// File: doc/BRIEF.md
# Flash Block-Erase Sequencer

This block sits on the host side of a NAND-style flash device and runs a full single-block erase over the device's memory-mapped register bus. The host raises a start request with a block address, a die-select bit and a data-buffer-select bit, plus a few configuration flags. The sequencer then performs its register accesses in a fixed order. It writes the block address, optionally writes the buffer select, and issues the erase command. It then reads the interrupt register until the completion flag rises, optionally clears that flag, reads the controller status, and optionally reads the write-protection state.

The result comes back with a one-cycle done pulse. The result holds an error flag, a timeout flag, the failing block number (so that the host can retire that block and pick a spare), and the three protection indications. The bus is a simple synchronous one. Each access holds its address, write data and strobe until the device answers with ready.

Top module: `flash_erase_seq`

## Requirements
- R1: A start request is taken only while `busy_o` is low. `busy_o` rises on the next cycle and stays high up to and including a single-cycle `done_o` pulse, then falls. A start request while busy has no effect.
- R2: The first access is a write to 0xF100. Its data carries the die-select bit at bit 15 and the block address in the low BLK_W bits, with every other bit zero.
- R3: When `dual_die_i` is set, the next access is a write to 0xF101 with the buffer-select bit at bit 15 and all other bits zero. When `dual_die_i` is clear, this write is left out.
- R4: The erase command follows as a write of 0x0094 to 0xF220, and the access after it is a read of 0xF241.
- R5: The sequencer keeps reading 0xF241 and treats the erase as finished only on a read with bit 15 set that follows a read with bit 15 clear. A bit 15 already high on the first read does not count.
- R6: After completion, 0x0000 is written to 0xF241 unless `auto_int_i` is set, in which case this write is skipped.
- R7: Next, 0xF240 is read. `err_o` takes its bit 10, and `fail_blk_o` shows the block address when that bit is set and zero otherwise.
- R8: When `wp_rd_en_i` is set, a final read of 0xF24E loads `wp_stat_o` from its bits 2:0 (bit 2 unlocked, bit 1 locked, bit 0 locked-tight). Otherwise `wp_stat_o` is zero.
- R9: If completion is not seen within max(`tmo_limit_i`,1) interrupt reads, the sequence ends at once with `tmo_o` and `err_o` set and `fail_blk_o` holding the block address. In that case the clear, status and protection accesses are not made.
- R10: Each access keeps address, write data and strobe unchanged until ready is sampled high. Read and write strobes are never high together.
- R11: All request and configuration inputs are captured when a start is accepted. Later changes have no effect on the running sequence. The results are valid with `done_o` and held until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Erase request |
| die_sel_i | input | 1 | Die select placed in the block-address write |
| buf_sel_i | input | 1 | Data-buffer select for dual-die parts |
| blk_i | input | BLK_W | Block to erase |
| dual_die_i | input | 1 | Device has two dies; enables the buffer-select write |
| auto_int_i | input | 1 | Interrupt auto-clear mode; skips the clear write |
| wp_rd_en_i | input | 1 | Read protection state after status |
| tmo_limit_i | input | TMO_W | Maximum number of interrupt polls (0 acts as 1) |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_rdata_i | input | 16 | Read data, valid with ready |
| bus_rdy_i | input | 1 | Access completes on a clock edge where this is high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Erase failed or timed out |
| tmo_o | output | 1 | Poll limit reached without completion |
| fail_blk_o | output | BLK_W | Failing block, zero on success |
| wp_stat_o | output | 3 | Unlocked, locked, locked-tight |

## Verification
The assertions assume that the device answers each strobe with ready at some later point, and that read data is meaningful only in the cycle ready is high. The bench device model follows this. It drives ready after a chosen number of wait cycles for every access and answers reads by address.

The start request is assumed to be a clean level sampled at the clock edge. The bench changes it and all configuration inputs only midway between edges. It also deliberately raises it, with altered configuration, during a running erase.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;
  localparam int FES_AW = 16;
  localparam int FES_DW = 16;

  localparam logic [FES_AW-1:0] FES_A_BLK  = 16'hF100;
  localparam logic [FES_AW-1:0] FES_A_BUF  = 16'hF101;
  localparam logic [FES_AW-1:0] FES_A_CMD  = 16'hF220;
  localparam logic [FES_AW-1:0] FES_A_INT  = 16'hF241;
  localparam logic [FES_AW-1:0] FES_A_STAT = 16'hF240;
  localparam logic [FES_AW-1:0] FES_A_WP   = 16'hF24E;

  localparam logic [FES_DW-1:0] FES_ERASE_CODE = 16'h0094;
  localparam int FES_INT_BIT = 15;
  localparam int FES_ERR_BIT = 10;

  typedef enum logic [3:0] {
    S_IDLE, S_WBLK, S_WBUF, S_WCMD, S_POLL, S_WCLR, S_RSTAT, S_RWP, S_FIN
  } fes_state_t;

  // Block-address word: die select on top, block in the low bits
  function automatic logic [FES_DW-1:0] fes_blk_word(input logic die, input logic [FES_DW-2:0] blk);
    return {die, blk};
  endfunction

  function automatic logic [FES_DW-1:0] fes_buf_word(input logic bsel);
    return {bsel, {(FES_DW-1){1'b0}}};
  endfunction

  // Effective poll budget: zero behaves as one
  function automatic int unsigned fes_poll_budget(input int unsigned lim);
    return (lim == 0) ? 1 : lim;
  endfunction
endpackage

// File: rtl/fes_bus_drive.sv
`timescale 1ns/1ps
module fes_bus_drive
  import fes_pkg::*;
(
  input  fes_state_t          state_i,
  input  logic                die_i,
  input  logic                buf_i,
  input  logic [FES_DW-2:0]   blk_i,
  output logic [FES_AW-1:0]   addr_o,
  output logic [FES_DW-1:0]   wdata_o,
  output logic                rd_o,
  output logic                wr_o
);
  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    unique case (state_i)
      S_WBLK:  begin addr_o = FES_A_BLK;  wdata_o = fes_blk_word(die_i, blk_i); wr_o = 1'b1; end
      S_WBUF:  begin addr_o = FES_A_BUF;  wdata_o = fes_buf_word(buf_i);        wr_o = 1'b1; end
      S_WCMD:  begin addr_o = FES_A_CMD;  wdata_o = FES_ERASE_CODE;             wr_o = 1'b1; end
      S_POLL:  begin addr_o = FES_A_INT;  rd_o = 1'b1; end
      S_WCLR:  begin addr_o = FES_A_INT;  wr_o = 1'b1; end
      S_RSTAT: begin addr_o = FES_A_STAT; rd_o = 1'b1; end
      S_RWP:   begin addr_o = FES_A_WP;   rd_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fes_poll_timer.sv
`timescale 1ns/1ps
module fes_poll_timer
  import fes_pkg::*;
#(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             miss_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int CW = TMO_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_eff_w;
  logic [CW-1:0] cnt_next_w;

  assign lim_eff_w  = CW'(fes_poll_budget(int'(limit_i)));
  assign cnt_next_w = cnt_q + CW'(1);
  assign expire_o   = miss_i && (cnt_next_w >= lim_eff_w);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (miss_i && !expire_o) cnt_q <= cnt_next_w;
  end

  // R9: the count of unanswered polls never reaches the budget
  assert_poll_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_eff_w);
endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int BLK_W = 10,
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             die_sel_i,
  input  logic             buf_sel_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             dual_die_i,
  input  logic             auto_int_i,
  input  logic             wp_rd_en_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic [15:0]      bus_addr_o,
  output logic [15:0]      bus_wdata_o,
  output logic             bus_rd_o,
  output logic             bus_wr_o,
  input  logic [15:0]      bus_rdata_i,
  input  logic             bus_rdy_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             tmo_o,
  output logic [BLK_W-1:0] fail_blk_o,
  output logic [2:0]       wp_stat_o
);
  localparam int BLK_EXT_W = FES_DW - 1;

  fes_state_t       state_q;
  logic             die_q, buf_q, dual_q, auto_q, wpen_q;
  logic [BLK_W-1:0] blk_q;
  logic [TMO_W-1:0] lim_q;
  logic             armed_q;
  logic             err_q, tmo_q;
  logic [BLK_W-1:0] fail_q;
  logic [2:0]       wp_q;

  // Named events
  logic acc_w, start_acc_w, rise_w, miss_w, expire_w;
  logic unused_rdata_w;

  assign acc_w       = (bus_rd_o || bus_wr_o) && bus_rdy_i;
  assign start_acc_w = start_i && (state_q == S_IDLE);
  assign rise_w      = acc_w && (state_q == S_POLL) && armed_q && bus_rdata_i[FES_INT_BIT];
  assign miss_w      = acc_w && (state_q == S_POLL) && !rise_w;
  assign unused_rdata_w = ^bus_rdata_i;

  fes_bus_drive u_bus (
    .state_i (state_q),
    .die_i   (die_q),
    .buf_i   (buf_q),
    .blk_i   (BLK_EXT_W'(blk_q)),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o),
    .rd_o    (bus_rd_o),
    .wr_o    (bus_wr_o)
  );

  fes_poll_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_acc_w),
    .miss_i   (miss_w),
    .limit_i  (lim_q),
    .expire_o (expire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      {die_q, buf_q, dual_q, auto_q, wpen_q, armed_q} <= '0;
      blk_q   <= '0;
      lim_q   <= '0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      fail_q  <= '0;
      wp_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_acc_w) begin
          die_q <= die_sel_i;  buf_q <= buf_sel_i;  dual_q <= dual_die_i;
          auto_q <= auto_int_i; wpen_q <= wp_rd_en_i;
          blk_q <= blk_i; lim_q <= tmo_limit_i;
          armed_q <= 1'b0;
          err_q <= 1'b0; tmo_q <= 1'b0; fail_q <= '0; wp_q <= '0;
          state_q <= S_WBLK;
        end
        S_WBLK:  if (acc_w) state_q <= dual_q ? S_WBUF : S_WCMD;
        S_WBUF:  if (acc_w) state_q <= S_WCMD;
        S_WCMD:  if (acc_w) state_q <= S_POLL;
        S_POLL: begin
          if (rise_w) state_q <= auto_q ? S_RSTAT : S_WCLR;
          else if (miss_w) begin
            if (!bus_rdata_i[FES_INT_BIT]) armed_q <= 1'b1;
            if (expire_w) begin
              tmo_q <= 1'b1; err_q <= 1'b1; fail_q <= blk_q;
              state_q <= S_FIN;
            end
          end
        end
        S_WCLR:  if (acc_w) state_q <= S_RSTAT;
        S_RSTAT: if (acc_w) begin
          err_q  <= bus_rdata_i[FES_ERR_BIT];
          fail_q <= bus_rdata_i[FES_ERR_BIT] ? blk_q : '0;
          state_q <= wpen_q ? S_RWP : S_FIN;
        end
        S_RWP:   if (acc_w) begin
          wp_q <= bus_rdata_i[2:0];
          state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign err_o      = err_q;
  assign tmo_o      = tmo_q;
  assign fail_blk_o = fail_q;
  assign wp_stat_o  = wp_q;

  // R10: a waiting access keeps its address, data and strobes
  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o || bus_wr_o) && !bus_rdy_i |=>
      $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_rd_o) && $stable(bus_wr_o));
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));
  // R1: accepted start makes busy; done lasts one cycle and ends busy
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_w |=> busy_o && !done_o);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  // R4: the command write is followed by an interrupt read
  assert_cmd_then_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && bus_wr_o && (bus_addr_o == FES_A_CMD) |=> bus_rd_o && (bus_addr_o == FES_A_INT));
  // R9: a timeout always carries the error flag
  assert_tmo_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> err_o);
  // R7: success reports no failing block
  assert_fail_blk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> fail_blk_o == '0);
endmodule

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;
  localparam int BLK_W = 10;
  localparam int TMO_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, die_sel_i = 1'b0, buf_sel_i = 1'b0;
  logic [BLK_W-1:0] blk_i = '0;
  logic dual_die_i = 1'b0, auto_int_i = 1'b0, wp_rd_en_i = 1'b0;
  logic [TMO_W-1:0] tmo_limit_i = '0;
  logic [15:0] bus_addr_o, bus_wdata_o;
  logic bus_rd_o, bus_wr_o;
  logic [15:0] bus_rdata_i = '0;
  logic bus_rdy_i = 1'b0;
  logic busy_o, done_o, err_o, tmo_o;
  logic [BLK_W-1:0] fail_blk_o;
  logic [2:0] wp_stat_o;

  always #10 clk = ~clk;

  flash_erase_seq #(.BLK_W(BLK_W), .TMO_W(TMO_W)) dut (.*);

  int checks = 0;
  int errors = 0;

  // expected accesses: {write, address, data}
  logic [32:0] exq[$];
  logic exp_err, exp_tmo;
  logic [BLK_W-1:0] exp_fail;
  logic [2:0] exp_wp;
  int wait_cfg = 0, wait_ctr = 0, rise_at = 0, poll_idx = 0;
  logic [15:0] stat_val = '0, wp_word = '0;
  bit exp_busy = 0, pend = 0;
  logic [15:0] p_addr, p_wd;
  logic p_rd, p_wr;
  int done_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [32:0] e);
    case (e[31:16])
      16'hF100: return "R2";
      16'hF101: return "R3";
      16'hF220: return "R4";
      16'hF241: return e[32] ? "R6" : "R5";
      16'hF240: return "R7";
      16'hF24E: return "R8";
      default:  return "R9";
    endcase
  endfunction

  function automatic logic [15:0] answer(input logic [15:0] a);
    case (a)
      16'hF241: return (poll_idx >= rise_at) ? 16'h8005 : 16'h0005;
      16'hF240: return stat_val;
      16'hF24E: return wp_word;
      default:  return 16'hDEAD;
    endcase
  endfunction

  // Device model and cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_rdy_i = 1'b0; exp_busy = 0; pend = 0;
    end else begin
      chk(busy_o == exp_busy, "R1", "busy", 64'(busy_o), 64'(exp_busy));
      if (pend)
        chk({bus_addr_o, bus_wdata_o, bus_rd_o, bus_wr_o} == {p_addr, p_wd, p_rd, p_wr},
            "R10", "held access", {bus_addr_o, bus_wdata_o, bus_rd_o, bus_wr_o},
            {p_addr, p_wd, p_rd, p_wr});
      if (bus_rd_o || bus_wr_o) begin
        chk(!(bus_rd_o && bus_wr_o), "R10", "both strobes", 64'({bus_rd_o, bus_wr_o}), 64'b10);
        if (wait_ctr == 0) begin
          bus_rdy_i = 1'b1;
          bus_rdata_i = bus_rd_o ? answer(bus_addr_o) : 16'h0;
          if (exq.size() == 0)
            chk(0, "R9", "unexpected access", {bus_wr_o, bus_addr_o}, 0);
          else begin
            logic [32:0] e;
            logic [32:0] a;
            e = exq.pop_front();
            a = {bus_wr_o, bus_addr_o, bus_wdata_o};
            if (!e[32]) begin a[15:0] = '0; e[15:0] = '0; end
            chk(a == e, tag_of(e), "access", 64'(a), 64'(e));
          end
          if (bus_rd_o && bus_addr_o == 16'hF241) poll_idx++;
          wait_ctr = wait_cfg;
          pend = 0;
        end else begin
          bus_rdy_i = 1'b0;
          wait_ctr--;
          pend = 1;
          p_addr = bus_addr_o; p_wd = bus_wdata_o; p_rd = bus_rd_o; p_wr = bus_wr_o;
        end
      end else begin
        bus_rdy_i = 1'b0;
        pend = 0;
      end
      if (done_o) begin
        chk(exq.size() == 0, "R9", "missing accesses", 64'(exq.size()), 0);
        chk(err_o == exp_err, "R7", "err", 64'(err_o), 64'(exp_err));
        chk(tmo_o == exp_tmo, "R9", "tmo", 64'(tmo_o), 64'(exp_tmo));
        chk(fail_blk_o == exp_fail, "R7", "fail_blk", 64'(fail_blk_o), 64'(exp_fail));
        chk(wp_stat_o == exp_wp, "R8", "wp_stat", 64'(wp_stat_o), 64'(exp_wp));
        done_seen++;
        exp_busy = 0;
      end
      if (start_i && !busy_o) exp_busy = 1;
    end
  end

  task automatic run_op(input bit die, input bit bsel, input logic [BLK_W-1:0] blk,
                        input bit dual, input bit auto_m, input bit wpen,
                        input int lim, input int rise, input logic [15:0] stat,
                        input logic [15:0] wpv, input int w, input bit poke);
    int budget;
    int polls;
    bit ok_path;
    int d0;
    int n;
    @(posedge clk); #5;
    die_sel_i = die; buf_sel_i = bsel; blk_i = blk; dual_die_i = dual;
    auto_int_i = auto_m; wp_rd_en_i = wpen; tmo_limit_i = TMO_W'(lim);
    budget = (lim == 0) ? 1 : lim;
    ok_path = (rise >= 1) && (rise <= budget - 1);
    polls = ok_path ? rise + 1 : budget;
    exq.delete();
    exq.push_back({1'b1, 16'hF100, die, 5'b0, blk});
    if (dual) exq.push_back({1'b1, 16'hF101, bsel, 15'b0});
    exq.push_back({1'b1, 16'hF220, 16'h0094});
    for (int i = 0; i < polls; i++) exq.push_back({1'b0, 16'hF241, 16'h0});
    if (ok_path) begin
      if (!auto_m) exq.push_back({1'b1, 16'hF241, 16'h0000});
      exq.push_back({1'b0, 16'hF240, 16'h0});
      if (wpen) exq.push_back({1'b0, 16'hF24E, 16'h0});
      exp_err = stat[10]; exp_tmo = 1'b0;
      exp_fail = stat[10] ? blk : '0;
      exp_wp = wpen ? wpv[2:0] : 3'b0;
    end else begin
      exp_err = 1'b1; exp_tmo = 1'b1; exp_fail = blk; exp_wp = 3'b0;
    end
    rise_at = rise; poll_idx = 0; stat_val = stat; wp_word = wpv;
    wait_cfg = w; wait_ctr = w;
    d0 = done_seen;
    start_i = 1'b1;
    @(posedge clk); #5;
    start_i = 1'b0;
    if (poke) begin  // R1, R11: start and new inputs during a running erase
      repeat (3) @(posedge clk);
      #5;
      start_i = 1'b1; blk_i = ~blk; die_sel_i = ~die; dual_die_i = ~dual;
      auto_int_i = ~auto_m; wp_rd_en_i = ~wpen; tmo_limit_i = '0;
      @(posedge clk); #5;
      start_i = 1'b0;
    end
    n = 0;
    while (done_seen == d0 && n < 3000) begin @(posedge clk); n++; end
    chk(n < 3000, "R1", "done never pulsed", 64'(n), 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, bus_rd_o, bus_wr_o, err_o, tmo_o} == 6'b0, "R1", "reset state",
        64'({busy_o, done_o, bus_rd_o, bus_wr_o, err_o, tmo_o}), 0);
    // single die, clear written, success
    run_op(0, 0, 10'h155, 0, 0, 0, 8, 3, 16'h0000, 16'h0, 0, 0);
    // dual die with buffer select, erase error, slow bus
    run_op(1, 1, 10'h3FF, 1, 0, 0, 8, 1, 16'h0400, 16'h0, 2, 0);
    // auto clear, protection read, other status bits set
    run_op(0, 1, 10'h001, 1, 1, 1, 6, 2, 16'hFBFF, 16'h0015, 1, 0);
    // R5: flag already high on first read never counts -> R9 timeout
    run_op(1, 0, 10'h0AA, 0, 0, 1, 4, 0, 16'h0000, 16'h0007, 0, 0);
    // R9: rise too late
    run_op(0, 1, 10'h222, 1, 1, 0, 5, 10, 16'h0000, 16'h0, 1, 0);
    // R9: zero limit acts as one poll
    run_op(0, 0, 10'h010, 0, 0, 0, 0, 1, 16'h0000, 16'h0, 0, 0);
    // R11: start and input changes while busy are ignored
    run_op(1, 0, 10'h2A5, 0, 1, 1, 10, 4, 16'h0400, 16'h0012, 2, 1);
    // R5/R9 boundary: rise on the last allowed poll
    run_op(0, 0, 10'h300, 0, 0, 0, 3, 2, 16'h0000, 16'h0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule